// File: doc/BRIEF.md
# Weighted-select stochastic dot product

The block forms a scaled dot product of several bipolar stochastic bit-streams with a set of fixed, signed weights. The weights never become bit-streams themselves. On every enabled cycle a pseudo-random number chooses one input lane, and each lane's chance of being chosen is proportional to its weight's magnitude. The chosen lane's bit goes to the output, and it is inverted when that weight is negative. The result at that point represents the weighted sum divided by the sum of the weight magnitudes.

A second stage moves the result to a power-of-two scale. It takes the XNOR of the stream with a constant stream whose bipolar value is the ratio of the magnitude sum to the next power of two at or above it. The decoded output times that power of two then estimates the true weighted sum.

A length counter counts the bits produced. It stops the block after a fixed stream length, and the block stays stopped until reset.

Top module: `stwd_dot`

## Requirements
- R1: The lane selector is a 16-bit LFSR. Its reset value is SEL_SEED (default 16'hACE1). Each step shifts the state left one bit and shifts in the XOR of state bits 15, 13, 12 and 10. On an enabled cycle with current state r, the chosen lane is the lowest index i for which (r+1)·S ≤ C_i·65536. Here S is the sum of all weight magnitudes and C_i is the sum of the magnitudes of lanes 0 to i. Exactly one lane is chosen.
- R2: The lane bit passed on is inverted when the chosen weight is negative. Weight i is the two's-complement value in WEIGHTS bits [8i+7:8i]. The default weights are lane0 = 3, lane1 = −2, lane2 = 0 and lane3 = 2.
- R3: A lane whose weight is zero is never chosen, so toggling its input leaves the output stream unchanged.
- R4: The rescale stage has a second LFSR of the same form whose reset value is RSC_SEED (default 16'h1D2B). With its state q, the constant bit is 1 exactly when (q+1)·P ≤ (P+S)·32768, where P is the smallest power of two ≥ S. The output bit is the XNOR of the signed lane bit and that constant bit.
- R5: An enabled cycle is one with en_i high while done_o is low. On an enabled cycle both LFSRs step once, and bit_o and vld_o take the new bit and 1 one cycle later. On any other cycle the LFSRs, bit_o and len_cnt_o hold, and vld_o is 0 one cycle later.
- R6: len_cnt_o counts enabled cycles. done_o is 1 exactly when len_cnt_o equals STREAM_LEN (default 1024). Once done_o is 1, en_i is ignored until reset.
- R7: While rst_n is low (asynchronous, active low), bit_o, vld_o and len_cnt_o are 0, done_o is 0, and both LFSRs hold their seeds.
- R8: Over a full stream, (2·ones/STREAM_LEN − 1)·P lies within 1.0 of Σ w_i·x_i. Here x_i is the bipolar value of lane i's bits on enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Produce one output bit this cycle |
| lane_i | input | N_LANES | One bipolar stream bit per lane |
| bit_o | output | 1 | Rescaled product stream bit |
| vld_o | output | 1 | bit_o was produced on the previous cycle |
| done_o | output | 1 | Stream length reached |
| len_cnt_o | output | $clog2(STREAM_LEN+1) | Bits produced so far |

## Verification
The bench drives the block with six input patterns:

- **All lanes at one.** Every output bit then depends only on the signs of the chosen weights and on the constant stream. This exposes a lost inversion or a wrong rescale constant as a shifted mean near +3.
- **All lanes at zero.** This mirrors the first pattern near −3.
- **Random lanes with uneven probabilities and gaps in the enable.** This tests the threshold walk against the reference on every bit, and it tests that idle cycles freeze the LFSRs.
- **Two runs with identical deterministic streams, once with the zero-weight lane held low and once with it toggling.** These must give identical one counts.
- **Enable held high past the stream length.** This shows that the counter and the output freeze.

// File: rtl/stwd_pkg.sv
package stwd_pkg;

  localparam int WMAX = 512;

  // Signed weight of lane i, taken from a flat vector of ww-bit fields.
  function automatic longint w_val(input logic [WMAX-1:0] wv, input int ww, input int i);
    logic [WMAX-1:0] sh;
    longint raw;
    sh  = wv >> (i * ww);
    raw = longint'(sh[62:0]) & ((longint'(1) << ww) - 1);
    if (raw >= (longint'(1) << (ww - 1))) raw = raw - (longint'(1) << ww);
    return raw;
  endfunction

  function automatic longint w_mag(input logic [WMAX-1:0] wv, input int ww, input int i);
    longint v;
    v = w_val(wv, ww, i);
    return (v < 0) ? -v : v;
  endfunction

  // Sum of magnitudes of lanes 0..i.
  function automatic longint cum_mag(input logic [WMAX-1:0] wv, input int ww, input int i);
    longint s;
    s = 0;
    for (int j = 0; j <= i; j++) s = s + w_mag(wv, ww, j);
    return s;
  endfunction

  function automatic longint pow2_ceil(input longint s);
    longint p;
    p = 1;
    while (p < s) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/stwd_lfsr.sv
module stwd_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_o <= SEED;
    else if (step_i) state_o <= {state_o[W-2:0], fb};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);  // R1

endmodule

// File: rtl/stwd_lane_sel.sv
module stwd_lane_sel #(
  parameter int                 N_LANES = 4,
  parameter int                 WW      = 8,
  parameter int                 RW      = 16,
  parameter logic [N_LANES*WW-1:0] WEIGHTS = 32'h02_00_FE_03
) (
  input  logic [RW-1:0]      rnd_i,
  input  logic [N_LANES-1:0] lane_i,
  output logic [N_LANES-1:0] sel_oh_o,
  output logic               bit_o
);
  import stwd_pkg::*;

  localparam logic [WMAX-1:0] WV  = WMAX'(WEIGHTS);
  localparam longint          TOT = cum_mag(WV, WW, N_LANES - 1);

  logic [N_LANES-1:0] below;
  logic [N_LANES-1:0] neg_mask;
  logic [RW:0]        rnd_x;

  assign rnd_x = {1'b0, rnd_i};

  for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
    // Cumulative threshold on the 2^RW scale; the last one equals 2^RW.
    localparam longint THR = (cum_mag(WV, WW, gi) << RW) / TOT;
    localparam logic [RW:0] THR_V = THR[RW:0];
    assign below[gi]    = rnd_x < THR_V;
    assign neg_mask[gi] = w_val(WV, WW, gi) < 0;
    if (gi == 0) begin : g_first
      assign sel_oh_o[gi] = below[gi];
    end else begin : g_rest
      assign sel_oh_o[gi] = below[gi] & ~below[gi-1];
    end
  end

  assign bit_o = |(sel_oh_o & (lane_i ^ neg_mask));

endmodule

// File: rtl/stwd_rescale.sv
module stwd_rescale #(
  parameter int     RW    = 16,
  parameter longint K_ONE = 61440
) (
  input  logic [RW-1:0] rnd_i,
  input  logic          y_i,
  output logic          const_o,
  output logic          z_o
);

  localparam logic [RW:0] K_V = K_ONE[RW:0];

  assign const_o = {1'b0, rnd_i} < K_V;
  assign z_o     = ~(y_i ^ const_o);

endmodule

// File: rtl/stwd_dot.sv
module stwd_dot #(
  parameter int                    N_LANES    = 4,
  parameter int                    WW         = 8,
  parameter logic [N_LANES*WW-1:0] WEIGHTS    = 32'h02_00_FE_03,
  parameter int                    STREAM_LEN = 1024,
  parameter logic [15:0]           SEL_SEED   = 16'hACE1,
  parameter logic [15:0]           RSC_SEED   = 16'h1D2B,
  localparam int                   CW         = $clog2(STREAM_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [N_LANES-1:0] lane_i,
  output logic               bit_o,
  output logic               vld_o,
  output logic               done_o,
  output logic [CW-1:0]      len_cnt_o
);
  import stwd_pkg::*;

  localparam int              RW    = 16;
  localparam logic [RW-1:0]   TAPS  = 16'hB400;
  localparam logic [WMAX-1:0] WV    = WMAX'(WEIGHTS);
  localparam longint          MSUM  = cum_mag(WV, WW, N_LANES - 1);
  localparam longint          P2    = pow2_ceil(MSUM);
  localparam longint          K_ONE = ((P2 + MSUM) << (RW - 1)) / P2;
  localparam logic [CW-1:0]   LEN_V = CW'(STREAM_LEN);

  logic               adv;
  logic [RW-1:0]      sel_rnd, rsc_rnd;
  logic [N_LANES-1:0] sel_oh;
  logic               signed_bit, const_bit, prod_bit;
  logic [N_LANES-1:0] zero_mask;

  assign done_o = (len_cnt_o == LEN_V);
  assign adv    = en_i && !done_o;

  for (genvar gi = 0; gi < N_LANES; gi++) begin : g_zm
    assign zero_mask[gi] = (w_mag(WV, WW, gi) == 0);
  end

  stwd_lfsr #(.W(RW), .TAPS(TAPS), .SEED(SEL_SEED)) sel_lfsr_i (
    .clk(clk), .rst_n(rst_n), .step_i(adv), .state_o(sel_rnd));

  stwd_lfsr #(.W(RW), .TAPS(TAPS), .SEED(RSC_SEED)) rsc_lfsr_i (
    .clk(clk), .rst_n(rst_n), .step_i(adv), .state_o(rsc_rnd));

  stwd_lane_sel #(.N_LANES(N_LANES), .WW(WW), .RW(RW), .WEIGHTS(WEIGHTS)) sel_i (
    .rnd_i(sel_rnd), .lane_i(lane_i), .sel_oh_o(sel_oh), .bit_o(signed_bit));

  stwd_rescale #(.RW(RW), .K_ONE(K_ONE)) rsc_i (
    .rnd_i(rsc_rnd), .y_i(signed_bit), .const_o(const_bit), .z_o(prod_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_cnt_o <= '0;
      bit_o     <= 1'b0;
      vld_o     <= 1'b0;
    end else begin
      vld_o <= adv;
      if (adv) begin
        len_cnt_o <= len_cnt_o + 1'b1;
        bit_o     <= prod_bit;
      end
    end
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> $countones(sel_oh) == 1);  // R1
  AST_SKIP_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (sel_oh & zero_mask) == '0);  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(bit_o) && !vld_o && $stable(len_cnt_o));  // R5
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    len_cnt_o <= LEN_V);  // R6
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && !vld_o);  // R6

endmodule

// File: tb/stwd_dot_tb.sv
`timescale 1ns/1ps
module stwd_dot_tb_top;

  localparam int L  = 1024;
  localparam int NL = 4;
  localparam int S  = 7;
  localparam int P  = 8;
  int wt [NL] = '{3, -2, 0, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [NL-1:0] lanes = '0;
  logic          bit_o, vld_o, done_o;
  logic [10:0]   len_cnt_o;

  always #5 clk = ~clk;

  stwd_dot dut_i (.clk(clk), .rst_n(rst_n), .en_i(en), .lane_i(lanes),
    .bit_o(bit_o), .vld_o(vld_o), .done_o(done_o), .len_cnt_o(len_cnt_o));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int r, q, mcnt;
  int e_bit, e_vld;
  int ones;
  int lane_ones [NL];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_near(input string tag, input real act, input real exp, input real tol);
    real d;
    checks++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  function automatic int lfsr_adv(input int s);
    int fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) & 16'hFFFF) | fb;
  endfunction

  task automatic model_reset();
    r = 16'hACE1; q = 16'h1D2B; mcnt = 0; e_bit = 0; e_vld = 0;
    ones = 0;
    for (int i = 0; i < NL; i++) lane_ones[i] = 0;
  endtask

  // One cycle: check the result of the previous edge, then drive and predict.
  task automatic step(input logic en_v, input logic [NL-1:0] ln);
    int cum, pick, y, c;
    @(negedge clk);
    chk("R1 bit_o", int'(bit_o), e_bit);
    chk("R5 vld_o", int'(vld_o), e_vld);
    chk("R6 len_cnt_o", int'(len_cnt_o), mcnt);
    chk("R6 done_o", int'(done_o), (mcnt == L) ? 1 : 0);
    if (vld_o && bit_o) ones++;
    en = en_v; lanes = ln;
    if (en_v && mcnt < L) begin
      cum = 0; pick = -1;
      for (int i = 0; i < NL; i++) begin
        cum += (wt[i] < 0) ? -wt[i] : wt[i];
        if (pick < 0 && longint'(r + 1) * S <= longint'(cum) * 65536) pick = i;
      end
      y = int'(ln[pick]) ^ ((wt[pick] < 0) ? 1 : 0);
      c = (longint'(q + 1) * P <= longint'(P + S) * 32768) ? 1 : 0;
      e_bit = (y == c) ? 1 : 0;
      e_vld = 1;
      for (int i = 0; i < NL; i++) if (ln[i]) lane_ones[i]++;
      mcnt++;
      r = lfsr_adv(r); q = lfsr_adv(q);
    end else begin
      e_vld = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // mode 0 all ones, 1 all zeros, 2 random with gaps, 3/4 deterministic
  task automatic run_stream(input int mode);
    int k;
    logic [NL-1:0] ln;
    logic e;
    k = 0;
    while (mcnt < L) begin
      e = 1'b1;
      case (mode)
        0: ln = '1;
        1: ln = '0;
        2: begin
          ln[0] = ($urandom % 100) < 80;
          ln[1] = ($urandom % 100) < 30;
          ln[2] = ($urandom % 100) < 50;
          ln[3] = ($urandom % 100) < 60;
          e = ($urandom % 4) != 0;
        end
        default: begin
          ln[0] = (k % 5) != 0;
          ln[1] = (k % 3) == 0;
          ln[2] = (mode == 4) ? ((k % 7) < 3) : 1'b0;
          ln[3] = (k % 2) == 1;
        end
      endcase
      step(e, ln);
      k++;
    end
    repeat (8) step(1'b1, '1);  // R6: en ignored after done
    step(1'b0, '0);
  endtask

  function automatic real decoded();
    return (2.0 * ones / L - 1.0) * P;
  endfunction

  function automatic real ref_sum();
    real s;
    s = 0.0;
    for (int i = 0; i < NL; i++) s += wt[i] * (2.0 * lane_ones[i] / L - 1.0);
    return s;
  endfunction

  initial begin
    int ones_a;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset bit_o", int'(bit_o), 0);
    chk("R7 reset vld_o", int'(vld_o), 0);
    chk("R7 reset len_cnt_o", int'(len_cnt_o), 0);
    chk("R7 reset done_o", int'(done_o), 0);
    rst_n = 1'b1;

    run_stream(0);
    chk_near("R2 R4 all-ones mean", decoded(), 3.0, 1.0);
    chk("R6 final count", int'(len_cnt_o), L);
    chk("R6 done held", int'(done_o), 1);

    do_reset();
    run_stream(1);
    chk_near("R2 R4 all-zeros mean", decoded(), -3.0, 1.0);

    do_reset();
    run_stream(2);
    chk_near("R8 random mean", decoded(), ref_sum(), 1.0);

    do_reset();
    run_stream(3);
    ones_a = ones;
    do_reset();
    run_stream(4);
    chk("R3 zero-weight lane ignored", ones, ones_a);
    chk_near("R8 deterministic mean", decoded(), ref_sum(), 1.0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule